// File: doc/BRIEF.md
# Token-Driven Machine Wrapper

This block runs a small synchronous state machine as a node in a dataflow network. The machine has two operand streams, `x` and `y`, and two result streams. Each stream passes through a small valid/ready queue. One model cycle is one token taken from each operand queue. In that cycle the machine produces one token on each result queue. The timing between tokens is free, so neighbouring nodes may stall or run at any rate without changing any value.

The sum result is `x + acc`, where `acc` is a 16-bit accumulator that starts at zero. It needs both operand heads. The echo result is the head of `y`, and it needs only that operand. Each result fires on its own as soon as its operands are present and its queue has room. It then marks itself done for the current model cycle. When both results are done, a separate retire step removes one token from each operand queue. In the same step it adds the `y` token to the accumulator and clears both done marks. Because the echo result never waits on `x`, a consumer of the echo result can make progress while `x` is late. This removes the false dependency that would otherwise cause deadlock.

Top module: `tkw_wrap`

## Requirements
- R1: The sum result fires when both operand heads are present, its output queue has room and it has not yet fired in the current model cycle. It carries `(x + acc) mod 2^16`.
- R2: The echo result fires when the `y` head is present, its output queue has room and it has not yet fired. It carries the `y` head. It does not depend on whether an `x` token is present.
- R3: Each result fires at most once per model cycle, even when its operand heads stay present.
- R4: The retire step happens only after both results have fired in the current model cycle. It removes exactly one token from each operand queue and sets `acc` to `(acc + y) mod 2^16`.
- R5: The n-th token read from each result port equals what the bare machine gives in cycle n. This holds for any pattern of producer delays and consumer stalls.
- R6: After synchronous reset, both result ports show no valid token, the operand ports are ready, and `acc` is 0, so the first sum equals the first `x`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| x_valid | input | 1 | Operand x token offered |
| x_ready | output | 1 | Operand x queue has room |
| x_data | input | 16 | Operand x value |
| y_valid | input | 1 | Operand y token offered |
| y_ready | output | 1 | Operand y queue has room |
| y_data | input | 16 | Operand y value |
| sum_valid | output | 1 | Sum token available |
| sum_ready | input | 1 | Consumer takes the sum token |
| sum_data | output | 16 | Sum value `x + acc` |
| echo_valid | output | 1 | Echo token available |
| echo_ready | input | 1 | Consumer takes the echo token |
| echo_data | output | 16 | Echo of operand y |

## Verification
The two results can fire in the same cycle. An operand can also enter its queue in the same cycle that the retire step removes the previous token. The random phase causes both overlaps by offering operands back to back while the consumers stall on independent random patterns. Each result token is compared in order against a reference that the bench computes one model cycle at a time. A directed opening first supplies only `y`. It confirms that the echo result appears alone, that it does not repeat when a second `y` is queued, and that supplying `x` then releases the sum and advances to the next echo.

// File: rtl/tkw_pkg.sv
package tkw_pkg;
    localparam int unsigned WORD_W = 16;
    typedef logic [WORD_W-1:0] word_t;

    // operand lanes of the wrapped machine
    typedef enum logic {LANE_X = 1'b0, LANE_Y = 1'b1} lane_e;
    localparam int unsigned NUM_LANES = 2;

    // result function: depends on x, y (presence) and state
    function automatic word_t sum_fn(input word_t x, input word_t acc);
        return x + acc;
    endfunction

    // state update function
    function automatic word_t acc_next_fn(input word_t acc, input word_t y);
        return acc + y;
    endfunction
endpackage

// File: rtl/tkw_fifo.sv
module tkw_fifo #(
    parameter int DEPTH = 2,
    parameter int W     = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          push, pop;

    assign in_ready  = (cnt != CW'(DEPTH));
    assign out_valid = (cnt != '0);
    assign out_data  = mem[rp];
    assign push      = in_valid && in_ready;
    assign pop       = out_valid && out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) begin
                mem[wp] <= in_data;
                wp      <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            end
            if (pop) begin
                rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            end
            case ({push, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // R5
    head_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/tkw_core.sv
module tkw_core
    import tkw_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  x_avail,
    input  word_t x_head,
    input  logic  y_avail,
    input  word_t y_head,
    input  logic  sum_room,
    input  logic  echo_room,
    output logic  sum_push,
    output word_t sum_val,
    output logic  echo_push,
    output word_t echo_val,
    output logic  retire
);
    word_t acc;
    logic  sum_done, echo_done;

    // each result watches only the operands it depends on
    assign sum_push  = x_avail && y_avail && sum_room && !sum_done;
    assign echo_push = y_avail && echo_room && !echo_done;
    assign sum_val   = sum_fn(x_head, acc);
    assign echo_val  = y_head;
    assign retire    = sum_done && echo_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc       <= '0;
            sum_done  <= 1'b0;
            echo_done <= 1'b0;
        end else if (retire) begin
            acc       <= acc_next_fn(acc, y_head);
            sum_done  <= 1'b0;
            echo_done <= 1'b0;
        end else begin
            if (sum_push)  sum_done  <= 1'b1;
            if (echo_push) echo_done <= 1'b1;
        end
    end

    // R1
    sum_needs_both_chk: assert property (@(posedge clk) disable iff (rst)
        sum_push |-> (x_avail && y_avail));
    // R2
    echo_needs_y_chk: assert property (@(posedge clk) disable iff (rst)
        echo_push |-> y_avail);
    // R3
    sum_once_chk: assert property (@(posedge clk) disable iff (rst)
        sum_push |=> !sum_push);
    // R3
    echo_once_chk: assert property (@(posedge clk) disable iff (rst)
        echo_push |=> !echo_push);
    // R4
    retire_heads_chk: assert property (@(posedge clk) disable iff (rst)
        retire |-> (x_avail && y_avail && !sum_push && !echo_push));
    // R4
    retire_clears_chk: assert property (@(posedge clk) disable iff (rst)
        retire |=> !retire);
endmodule

// File: rtl/tkw_wrap.sv
module tkw_wrap
    import tkw_pkg::*;
#(
    parameter int IN_DEPTH  = 2,
    parameter int OUT_DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         x_valid,
    output logic         x_ready,
    input  logic [15:0]  x_data,
    input  logic         y_valid,
    output logic         y_ready,
    input  logic [15:0]  y_data,
    output logic         sum_valid,
    input  logic         sum_ready,
    output logic [15:0]  sum_data,
    output logic         echo_valid,
    input  logic         echo_ready,
    output logic [15:0]  echo_data
);
    logic  in_valid [NUM_LANES];
    logic  in_ready [NUM_LANES];
    word_t in_data  [NUM_LANES];
    logic  hd_valid [NUM_LANES];
    word_t hd_data  [NUM_LANES];

    logic  sum_push, echo_push, retire;
    logic  sum_room, echo_room;
    word_t sum_val, echo_val;

    assign in_valid[LANE_X] = x_valid;
    assign in_data[LANE_X]  = x_data;
    assign in_valid[LANE_Y] = y_valid;
    assign in_data[LANE_Y]  = y_data;
    assign x_ready          = in_ready[LANE_X];
    assign y_ready          = in_ready[LANE_Y];

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_in
        tkw_fifo #(.DEPTH(IN_DEPTH), .W(WORD_W)) u_q (
            .clk       (clk),
            .rst       (rst),
            .in_valid  (in_valid[i]),
            .in_ready  (in_ready[i]),
            .in_data   (in_data[i]),
            .out_valid (hd_valid[i]),
            .out_ready (retire),
            .out_data  (hd_data[i])
        );
    end

    tkw_core u_core (
        .clk       (clk),
        .rst       (rst),
        .x_avail   (hd_valid[LANE_X]),
        .x_head    (hd_data[LANE_X]),
        .y_avail   (hd_valid[LANE_Y]),
        .y_head    (hd_data[LANE_Y]),
        .sum_room  (sum_room),
        .echo_room (echo_room),
        .sum_push  (sum_push),
        .sum_val   (sum_val),
        .echo_push (echo_push),
        .echo_val  (echo_val),
        .retire    (retire)
    );

    tkw_fifo #(.DEPTH(OUT_DEPTH), .W(WORD_W)) u_sum_q (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (sum_push),
        .in_ready  (sum_room),
        .in_data   (sum_val),
        .out_valid (sum_valid),
        .out_ready (sum_ready),
        .out_data  (sum_data)
    );

    tkw_fifo #(.DEPTH(OUT_DEPTH), .W(WORD_W)) u_echo_q (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (echo_push),
        .in_ready  (echo_room),
        .in_data   (echo_val),
        .out_valid (echo_valid),
        .out_ready (echo_ready),
        .out_data  (echo_data)
    );
endmodule

// File: tb/tkw_wrap_tb.sv
module tkw_wrap_tb_top;
    localparam int N = 200;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        x_valid = 1'b0, y_valid = 1'b0;
    logic [15:0] x_data = '0, y_data = '0;
    logic        sum_ready = 1'b0, echo_ready = 1'b0;
    logic        x_ready, y_ready, sum_valid, echo_valid;
    logic [15:0] sum_data, echo_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [15:0] xv [N];
    logic [15:0] yv [N];
    logic [15:0] exp_sum [N];
    logic [15:0] exp_echo [N];
    int sum_idx = 0, echo_idx = 0;

    always #10 clk = ~clk;

    tkw_wrap dut_i (
        .clk(clk), .rst(rst),
        .x_valid(x_valid), .x_ready(x_ready), .x_data(x_data),
        .y_valid(y_valid), .y_ready(y_ready), .y_data(y_data),
        .sum_valid(sum_valid), .sum_ready(sum_ready), .sum_data(sum_data),
        .echo_valid(echo_valid), .echo_ready(echo_ready), .echo_data(echo_data)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // reference machine, one model cycle at a time
    function automatic void build_ref();
        logic [15:0] acc = '0;
        for (int n = 0; n < N; n++) begin
            exp_sum[n]  = xv[n] + acc;
            exp_echo[n] = yv[n];
            acc         = acc + yv[n];
        end
    endfunction

    task automatic put_x(input logic [15:0] v, input int gap);
        repeat (gap) begin @(negedge clk); x_valid = 1'b0; end
        @(negedge clk); x_valid = 1'b1; x_data = v;
        while (!x_ready) @(negedge clk);
        @(posedge clk);
        #1 x_valid = 1'b0;
    endtask

    task automatic put_y(input logic [15:0] v, input int gap);
        repeat (gap) begin @(negedge clk); y_valid = 1'b0; end
        @(negedge clk); y_valid = 1'b1; y_data = v;
        while (!y_ready) @(negedge clk);
        @(posedge clk);
        #1 y_valid = 1'b0;
    endtask

    task automatic prod_x();
        for (int i = 1; i < N; i++) put_x(xv[i], int'($urandom % 4));
    endtask

    task automatic prod_y();
        for (int i = 2; i < N; i++) put_y(yv[i], int'($urandom % 4));
    endtask

    task automatic cons_sum();
        while (sum_idx < N) begin
            @(negedge clk);
            sum_ready = ($urandom % 3) != 0;
            if (sum_valid && sum_ready) begin
                chk($sformatf("R5 sum[%0d]", sum_idx), sum_data, exp_sum[sum_idx]);
                sum_idx++;
            end
        end
        @(negedge clk); sum_ready = 1'b0;
    endtask

    task automatic cons_echo();
        while (echo_idx < N) begin
            @(negedge clk);
            echo_ready = ($urandom % 3) != 0;
            if (echo_valid && echo_ready) begin
                chk($sformatf("R5 echo[%0d]", echo_idx), echo_data, exp_echo[echo_idx]);
                echo_idx++;
            end
        end
        @(negedge clk); echo_ready = 1'b0;
    endtask

    initial begin
        process::self().srandom(32'h5EED_0101);
        for (int n = 0; n < N; n++) begin
            xv[n] = 16'($urandom);
            yv[n] = 16'($urandom);
        end
        xv[0] = 16'h1234; yv[0] = 16'hFFF0;
        xv[1] = 16'h0020;               // sum[1] wraps: 0x0020 + 0xFFF0
        build_ref();

        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R6 reset state
        chk("R6 sum_valid",  {15'd0, sum_valid},  16'd0);
        chk("R6 echo_valid", {15'd0, echo_valid}, 16'd0);
        chk("R6 x_ready",    {15'd0, x_ready},    16'd1);
        chk("R6 y_ready",    {15'd0, y_ready},    16'd1);

        // R2: echo appears with x absent
        put_y(yv[0], 0);
        repeat (3) @(negedge clk);
        chk("R2 echo_valid without x", {15'd0, echo_valid}, 16'd1);
        chk("R2 echo_data", echo_data, yv[0]);
        chk("R1 sum waits for x", {15'd0, sum_valid}, 16'd0);
        echo_ready = 1'b1;
        @(negedge clk); echo_ready = 1'b0;
        echo_idx = 1;

        // R3: second y queued, echo must not fire again in this model cycle
        put_y(yv[1], 0);
        repeat (4) @(negedge clk);
        chk("R3 no repeat echo", {15'd0, echo_valid}, 16'd0);

        // R1, R4, R6: x releases sum (acc=0), retire exposes next echo
        put_x(xv[0], 0);
        repeat (4) @(negedge clk);
        chk("R1 sum_valid", {15'd0, sum_valid}, 16'd1);
        chk("R6 first sum equals x", sum_data, xv[0]);
        chk("R4 next echo after retire", echo_data, yv[1]);
        chk("R4 y queue freed", {15'd0, y_ready}, 16'd1);

        // random phase: sum[1] checks R4 accumulator update and wrap
        fork
            prod_x();
            prod_y();
            cons_sum();
            cons_echo();
        join
        repeat (6) @(negedge clk);
        chk("R3 sum idle at end",  {15'd0, sum_valid},  16'd0);
        chk("R3 echo idle at end", {15'd0, echo_valid}, 16'd0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R5 actual=%0d expected=%0d", sum_idx, N);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule